// File: doc/BRIEF.md
# Quarter-Second Time Base with Multi-Second Match

This block keeps a running count of quarter seconds. An external clock-enable input stands in for the selected time source. The block divides those pulses by a programmable divisor to make a 4 Hz tick, and each tick advances an 8-bit counter. The counter covers 64 seconds and then wraps.

On every tick the block raises a quarter-second flag. It raises a one-second flag when the two low counter bits roll over. A match unit holds a 6-bit seconds value. When that value is written, the match unit also latches the counter's current sub-second bits, so the compare value keeps the present quarter-second phase. On a match, only the seconds part of the counter is cleared, which makes the block produce events at a fixed multi-second period.

Each flag is cleared by software through a pulse input. A single interrupt line combines the flags, and each flag has its own enable.

Top module: `qsec_timebase`

## Requirements
- R1: After reset the counter reads 0x00, all three flags and the interrupt are low, and the divisor reads DIV_RESET (default 8192).
- R2: While running, one tick occurs for every N pulses of src_tick, where N is the divisor (0 acts as 1). Each tick adds one to the counter, which wraps from 0xFF to 0x00.
- R3: qtr_flag is set on every tick. sec_flag is set only on the tick where the counter's bits [1:0] go from 3 to 0.
- R4: A cnt_clear pulse sets the counter to 0x00 and restarts the prescaler, so the next tick needs a full N pulses.
- R5: A match_wr pulse loads match_val into the seconds field. In the same cycle it copies the counter's current bits [1:0] into the quarter-second field, which is visible on match_qsec.
- R6: With match_en high, a tick whose incremented count equals {seconds field, match_qsec} sets mat_flag. That tick loads the counter with {6'b0, incremented[1:0]}; for example, seconds 0x3C with phase 0 sends 0xEF to 0x00.
- R7: With match_en low, the counter passes the compare value unchanged and mat_flag stays low.
- R8: div_wr loads div_val only while run_en is low. A write while running leaves div_out unchanged.
- R9: While run_en is low, src_tick has no effect: the counter and prescaler hold and no flag is set.
- R10: A high clear input drops its flag on the next edge. If a set and a clear of the same flag happen in one cycle, the flag ends up set.
- R11: irq is high exactly when some flag is high and its enable input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 1 | Time-source clock enable, one pulse per source period |
| run_en | input | 1 | Block enable |
| cnt_clear | input | 1 | Pulse: clear counter and prescaler |
| div_wr | input | 1 | Pulse: load divisor (only while disabled) |
| div_val | input | DIV_W | Divisor value to load |
| match_en | input | 1 | Match compare enable |
| match_wr | input | 1 | Pulse: load seconds field and capture phase |
| match_val | input | 6 | Seconds match value |
| qtr_clr | input | 1 | Clear quarter-second flag |
| sec_clr | input | 1 | Clear one-second flag |
| mat_clr | input | 1 | Clear match flag |
| qtr_ie | input | 1 | Quarter-second interrupt enable |
| sec_ie | input | 1 | One-second interrupt enable |
| mat_ie | input | 1 | Match interrupt enable |
| cnt_out | output | 8 | Counter value |
| match_qsec | output | 2 | Captured quarter-second phase |
| div_out | output | DIV_W | Current divisor |
| qtr_flag | output | 1 | Quarter-second flag |
| sec_flag | output | 1 | One-second flag |
| mat_flag | output | 1 | Match flag |
| irq | output | 1 | Interrupt request |

## Verification
A bad prescaler phase shows up on cnt_out within one divisor period: the counter steps one pulse too early or too late after a clear. A wrong captured phase or a wrong compare width appears when the match tick arrives. At that tick the counter either fails to drop to its low bits or drops at the wrong value, and mat_flag shows the same error. Flag and gating faults show on the flags and irq on the edge right after the tick or clear that should have moved them.

// File: rtl/qsec_timebase.sv
module qsec_timebase #(
  parameter int DIV_W = 16,
  parameter int DIV_RESET = 8192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic             run_en,
  input  logic             cnt_clear,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_val,
  input  logic             match_en,
  input  logic             match_wr,
  input  logic [5:0]       match_val,
  input  logic             qtr_clr,
  input  logic             sec_clr,
  input  logic             mat_clr,
  input  logic             qtr_ie,
  input  logic             sec_ie,
  input  logic             mat_ie,
  output logic [7:0]       cnt_out,
  output logic [1:0]       match_qsec,
  output logic [DIV_W-1:0] div_out,
  output logic             qtr_flag,
  output logic             sec_flag,
  output logic             mat_flag,
  output logic             irq
);

  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RESET);

  logic [DIV_W-1:0] div_q, pre_cnt;
  logic [7:0]       cnt_q, cnt_inc;
  logic [5:0]       sec_q;
  logic [1:0]       qsec_q;
  logic             pre_last, tick, hit;

  assign pre_last = ({1'b0, pre_cnt} + 1'b1) >= {1'b0, div_q};
  assign tick     = run_en & src_tick & pre_last & ~cnt_clear;
  assign cnt_inc  = cnt_q + 8'd1;
  assign hit      = match_en & (cnt_inc == {sec_q, qsec_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pre_cnt <= '0;
    else if (cnt_clear)
      pre_cnt <= '0;
    else if (run_en && src_tick)
      pre_cnt <= pre_last ? '0 : pre_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_clear)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= hit ? {6'b0, cnt_inc[1:0]} : cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      qsec_q <= '0;
    end else if (match_wr) begin
      sec_q  <= match_val;
      qsec_q <= cnt_q[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      div_q <= DIV_INIT;
    else if (div_wr && !run_en)
      div_q <= div_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qtr_flag <= 1'b0;
      sec_flag <= 1'b0;
      mat_flag <= 1'b0;
    end else begin
      qtr_flag <= tick | (qtr_flag & ~qtr_clr);
      sec_flag <= (tick & (cnt_q[1:0] == 2'd3)) | (sec_flag & ~sec_clr);
      mat_flag <= (tick & hit) | (mat_flag & ~mat_clr);
    end
  end

  assign cnt_out    = cnt_q;
  assign match_qsec = qsec_q;
  assign div_out    = div_q;
  assign irq        = (qtr_flag & qtr_ie) | (sec_flag & sec_ie) | (mat_flag & mat_ie);

  // R9
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cnt_clear) |=> $stable(cnt_q));

  // R9
  no_flag_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !$rose(qtr_flag));

  // R3
  sec_on_rollover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_flag) |-> (cnt_q[1:0] == 2'd0));

  // R6
  match_clears_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mat_flag) |-> (cnt_q[7:2] == 6'd0));

  // R8
  div_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> $stable(div_q));

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == 8'hFF && cnt_q != 8'hFF) |-> (cnt_q == 8'h00));

endmodule

// File: tb/qsec_timebase_bench.sv
module qsec_timebase_bench;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0;
  logic src_tick = 0, run_en = 0, cnt_clear = 0, div_wr = 0, match_en = 0, match_wr = 0;
  logic [DW-1:0] div_val = '0;
  logic [5:0] match_val = '0;
  logic qtr_clr = 0, sec_clr = 0, mat_clr = 0, qtr_ie = 0, sec_ie = 0, mat_ie = 0;
  logic [7:0] cnt_out;
  logic [1:0] match_qsec;
  logic [DW-1:0] div_out;
  logic qtr_flag, sec_flag, mat_flag, irq;

  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  qsec_timebase u_qsec_timebase (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .run_en(run_en), .cnt_clear(cnt_clear),
    .div_wr(div_wr), .div_val(div_val), .match_en(match_en), .match_wr(match_wr),
    .match_val(match_val), .qtr_clr(qtr_clr), .sec_clr(sec_clr), .mat_clr(mat_clr),
    .qtr_ie(qtr_ie), .sec_ie(sec_ie), .mat_ie(mat_ie), .cnt_out(cnt_out),
    .match_qsec(match_qsec), .div_out(div_out), .qtr_flag(qtr_flag), .sec_flag(sec_flag),
    .mat_flag(mat_flag), .irq(irq));

  // {pulses, expected count} with divisor 3, cumulative
  localparam logic [15:0] VEC [6] = '{
    {8'd3, 8'd1}, {8'd2, 8'd1}, {8'd1, 8'd2}, {8'd6, 8'd4}, {8'd9, 8'd7}, {8'd4, 8'd8}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) src_tick = 1;
      @(negedge clk) src_tick = 0;
    end
  endtask

  task automatic do_clear();
    @(negedge clk) cnt_clear = 1;
    @(negedge clk) cnt_clear = 0;
  endtask

  task automatic wr_div(input logic [DW-1:0] v);
    @(negedge clk) begin div_wr = 1; div_val = v; end
    @(negedge clk) div_wr = 0;
  endtask

  task automatic wr_match(input logic [5:0] v);
    @(negedge clk) begin match_wr = 1; match_val = v; end
    @(negedge clk) match_wr = 0;
  endtask

  task automatic clr_flags();
    @(negedge clk) begin qtr_clr = 1; sec_clr = 1; mat_clr = 1; end
    @(negedge clk) begin qtr_clr = 0; sec_clr = 0; mat_clr = 0; end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 cnt", cnt_out, 0);
    chk("R1 flags", {qtr_flag, sec_flag, mat_flag, irq}, 0);
    chk("R1 div", div_out, 8192);

    wr_div(3);
    run_en = 1;
    // R2 table walk
    foreach (VEC[i]) begin
      pulse(VEC[i][15:8]);
      chk("R2 count", cnt_out, VEC[i][7:0]);
    end

    // R4: prescaler phase restarts
    do_clear();
    chk("R4 clear", cnt_out, 0);
    pulse(2);
    chk("R4 no early tick", cnt_out, 0);
    pulse(1);
    chk("R4 full period", cnt_out, 1);

    // R3
    clr_flags();
    pulse(3);
    chk("R3 qtr set", qtr_flag, 1);
    chk("R3 sec not at 2", sec_flag, 0);
    pulse(3);
    chk("R3 sec not at 3", sec_flag, 0);
    pulse(3);
    chk("R3 sec at 3->0", {cnt_out, sec_flag}, {8'd4, 1'b1});

    // R10
    @(negedge clk) qtr_clr = 1;
    @(negedge clk) qtr_clr = 0;
    chk("R10 clear", qtr_flag, 0);
    pulse(2);
    @(negedge clk) begin src_tick = 1; qtr_clr = 1; end
    @(negedge clk) begin src_tick = 0; qtr_clr = 0; end
    chk("R10 set wins", {cnt_out, qtr_flag}, {8'd5, 1'b1});
    @(negedge clk) sec_clr = 1;
    @(negedge clk) sec_clr = 0;
    chk("R10 only own flag", {qtr_flag, sec_flag}, 2'b10);

    // R11
    chk("R11 gated off", irq, 0);
    @(negedge clk) qtr_ie = 1;
    #1 chk("R11 qtr enabled", irq, 1);
    @(negedge clk) begin qtr_ie = 0; mat_ie = 1; sec_ie = 1; end
    #1 chk("R11 other enables", irq, 0);

    // R8
    wr_div(5);
    chk("R8 ignored while running", div_out, 3);

    // R9
    @(negedge clk) run_en = 0;
    clr_flags();
    pulse(7);
    chk("R9 hold", cnt_out, 5);
    chk("R9 no flags", {qtr_flag, sec_flag, mat_flag}, 0);
    wr_div(1);
    chk("R8 write while disabled", div_out, 1);
    @(negedge clk) run_en = 1;

    // R5 / R6
    do_clear();
    wr_match(6'h3C);
    chk("R5 phase 0", match_qsec, 0);
    @(negedge clk) match_en = 1;
    clr_flags();
    pulse(239);
    chk("R6 before match", {cnt_out, mat_flag}, {8'hEF, 1'b0});
    pulse(1);
    chk("R6 match 0x3C", {cnt_out, mat_flag}, {8'h00, 1'b1});

    do_clear();
    @(negedge clk) mat_clr = 1;
    @(negedge clk) mat_clr = 0;
    pulse(2);
    wr_match(6'h01);
    chk("R5 phase 2", match_qsec, 2);
    pulse(3);
    chk("R6 approach", {cnt_out, mat_flag}, {8'd5, 1'b0});
    pulse(1);
    chk("R6 phase kept", {cnt_out, mat_flag}, {8'd2, 1'b1});

    // R7
    @(negedge clk) begin match_en = 0; mat_clr = 1; end
    @(negedge clk) mat_clr = 0;
    pulse(4);
    chk("R7 passes compare", {cnt_out, mat_flag}, {8'd6, 1'b0});
    pulse(1);
    chk("R7 continues", cnt_out, 7);

    // R2 wrap
    do_clear();
    pulse(255);
    chk("R2 at FF", cnt_out, 8'hFF);
    pulse(1);
    chk("R2 wrap", cnt_out, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule